// File: doc/BRIEF.md
# DRAM Refresh Interval Timer

This block paces DRAM refresh. A down-counter runs off the system clock and expires once per refresh interval. The interval is set by a 3-bit rate code, which selects a power-of-two multiple of a base period, and by a frequency select, which picks the base period's cycle count for a 100 MHz or a 66 MHz clock. Each expiry adds one to a pending-refresh count. The refresh request output is high whenever that count is non-zero.

The request and acknowledge pins form a handshake. The request is the valid side and the acknowledge is the ready side. The controller pulses acknowledge for one cycle for each refresh it has issued. The request does not drop while refreshes are still owed, so back-pressure from a busy controller costs no refresh: expiries pile up in the pending count, up to a saturating limit. A normal-refresh enable and the code fields gate the timer. Invalid settings stop the timer without losing refreshes already owed.

Top module: `refresh_timer`

## Requirements
- R1: During reset and at the first sample after reset, `refresh_req` is 0 and `pend_count` is 0.
- R2: With `freq_sel` = 2'b00 (100 MHz) and rate code k in 1..5, the interval is BASE_FAST << (k-1) cycles. The first expiry lands exactly that many cycles after the edge that starts the timer.
- R3: With `freq_sel` = 2'b10 (66 MHz), the interval is BASE_SLOW << (k-1) cycles, with the same start timing as R2.
- R4: Rate code 3'b000 stops the timer, and `pend_count` never rises.
- R5: Rate codes 3'b110 and 3'b111 are reserved and behave as code 3'b000.
- R6: Frequency codes 2'b01 and 2'b11 are reserved and stop the timer.
- R7: With `refresh_en` low, no expiry occurs. The pending count is kept and is not cleared.
- R8: `refresh_req` stays high until the pending count reaches zero. Each cycle with `refresh_ack` high while a request is pending lowers the count by exactly one.
- R9: Expiries that occur while refreshes are pending raise the count, which saturates at PEND_MAX (default 8).
- R10: A change of rate code or frequency select while running restarts the interval on that edge. The next expiry follows the full new interval.
- R11: `refresh_ack` while nothing is pending has no effect, and the count stays 0.
- R12: An expiry and an acknowledge in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_code | input | 3 | Refresh rate select; 0 off, 1..5 interval multiple, 6..7 reserved |
| freq_sel | input | 2 | Clock frequency strap; 00 = 100 MHz, 10 = 66 MHz, others reserved |
| refresh_en | input | 1 | Normal-refresh enable |
| refresh_ack | input | 1 | One pulse per refresh issued by the controller |
| refresh_req | output | 1 | High while any refresh is pending |
| pend_count | output | $clog2(PEND_MAX+1) | Number of pending refreshes |

## Verification
A wrong reload value or a missed restart moves the first rise of `refresh_req` off its expected cycle. This is seen within one interval, so the bench measures the cycle count to that rise for every code and frequency. A corrupted pending count shows on `pend_count` at the next edge, as a skipped step, a wrap past the saturation limit, or a failure to hold when an expiry and an acknowledge coincide. A decoder that lets a reserved code through shows a request within one longest interval, so the idle checks wait longer than that.

// File: rtl/refresh_timer_pkg.sv
package refresh_timer_pkg;

  typedef enum logic [2:0] {
    RATE_OFF  = 3'd0,
    RATE_X1   = 3'd1,
    RATE_X2   = 3'd2,
    RATE_X4   = 3'd3,
    RATE_X8   = 3'd4,
    RATE_X16  = 3'd5,
    RATE_RSV6 = 3'd6,
    RATE_RSV7 = 3'd7
  } rate_e;

  localparam logic [1:0] FREQ_FAST = 2'b00;
  localparam logic [1:0] FREQ_SLOW = 2'b10;

  // Largest shift applied to the base period (code RATE_X16).
  localparam int MAX_SHIFT = 4;

  function automatic logic rate_is_live(input logic [2:0] code);
    return (code >= 3'(RATE_X1)) && (code <= 3'(RATE_X16));
  endfunction

  function automatic logic freq_is_live(input logic [1:0] f);
    return (f == FREQ_FAST) || (f == FREQ_SLOW);
  endfunction

endpackage

// File: rtl/refresh_rate_decode.sv
module refresh_rate_decode
  import refresh_timer_pkg::*;
#(
  parameter int BASE_FAST = 1560,
  parameter int BASE_SLOW = 1030,
  parameter int CNT_W     = 15
) (
  input  logic [2:0]       rate_code,
  input  logic [1:0]       freq_sel,
  output logic             cfg_live,
  output logic [CNT_W-1:0] reload_val
);

  logic [CNT_W:0] base_cycles;
  logic [CNT_W:0] span;
  logic [2:0]     shift_amt;

  always_comb begin
    cfg_live    = rate_is_live(rate_code) && freq_is_live(freq_sel);
    base_cycles = (freq_sel == FREQ_FAST) ? (CNT_W+1)'(BASE_FAST)
                                          : (CNT_W+1)'(BASE_SLOW);
    shift_amt   = cfg_live ? (rate_code - 3'd1) : 3'd0;
    span        = base_cycles << shift_amt;
    // Counter runs from span-1 down to zero, giving span cycles per expiry.
    reload_val  = cfg_live ? CNT_W'(span - (CNT_W+1)'(1)) : '0;
  end

endmodule

// File: rtl/refresh_interval_counter.sv
module refresh_interval_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [2:0]       rate_code,
  input  logic [1:0]       freq_sel,
  input  logic [CNT_W-1:0] reload_val,
  output logic             expire
);

  logic [CNT_W-1:0] remain;
  logic             run_q;
  logic [2:0]       rate_q;
  logic [1:0]       freq_q;
  logic             restart;

  always_comb begin
    restart = run && (!run_q || (rate_code != rate_q) || (freq_sel != freq_q));
    expire  = run && !restart && (remain == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      run_q  <= 1'b0;
      rate_q <= '0;
      freq_q <= '0;
    end else begin
      run_q  <= run;
      rate_q <= rate_code;
      freq_q <= freq_sel;
      if (!run)
        remain <= '0;
      else if (restart || (remain == '0))
        remain <= reload_val;
      else
        remain <= remain - CNT_W'(1);
    end
  end

endmodule

// File: rtl/refresh_pending_tracker.sv
module refresh_pending_tracker #(
  parameter int PEND_MAX = 8,
  parameter int PEND_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              ack,
  output logic              req,
  output logic [PEND_W-1:0] count
);

  logic take;
  logic at_top;

  always_comb begin
    req    = (count != '0);
    take   = ack && req;
    at_top = (count == PEND_W'(PEND_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      unique case ({expire, take})
        2'b10:   if (!at_top) count <= count + PEND_W'(1);
        2'b01:   count <= count - PEND_W'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/refresh_timer.sv
module refresh_timer
  import refresh_timer_pkg::*;
#(
  parameter int BASE_FAST = 1560,
  parameter int BASE_SLOW = 1030,
  parameter int PEND_MAX  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    rate_code,
  input  logic [1:0]                    freq_sel,
  input  logic                          refresh_en,
  input  logic                          refresh_ack,
  output logic                          refresh_req,
  output logic [$clog2(PEND_MAX+1)-1:0] pend_count
);

  localparam int BASE_MAX = (BASE_FAST > BASE_SLOW) ? BASE_FAST : BASE_SLOW;
  localparam int CNT_W    = $clog2(BASE_MAX << MAX_SHIFT);
  localparam int PEND_W   = $clog2(PEND_MAX + 1);

  logic             cfg_live;
  logic [CNT_W-1:0] reload_val;
  logic             run;
  logic             expire;

  refresh_rate_decode #(
    .BASE_FAST (BASE_FAST),
    .BASE_SLOW (BASE_SLOW),
    .CNT_W     (CNT_W)
  ) u_decode (
    .rate_code  (rate_code),
    .freq_sel   (freq_sel),
    .cfg_live   (cfg_live),
    .reload_val (reload_val)
  );

  assign run = cfg_live && refresh_en;

  refresh_interval_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .rate_code  (rate_code),
    .freq_sel   (freq_sel),
    .reload_val (reload_val),
    .expire     (expire)
  );

  refresh_pending_tracker #(
    .PEND_MAX (PEND_MAX),
    .PEND_W   (PEND_W)
  ) u_pending (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .ack    (refresh_ack),
    .req    (refresh_req),
    .count  (pend_count)
  );

endmodule

// File: rtl/refresh_timer_chk.sv
module refresh_timer_chk #(
  parameter int PEND_MAX = 8,
  parameter int PEND_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        rate_code,
  input logic [1:0]        freq_sel,
  input logic              refresh_en,
  input logic              refresh_ack,
  input logic              refresh_req,
  input logic [PEND_W-1:0] pend_count,
  input logic              expire
);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_count <= PEND_W'(PEND_MAX));

  p_hold_until_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_ack) |=> refresh_req);

  p_ack_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_ack && refresh_req && !expire) |=> (pend_count == $past(pend_count) - PEND_W'(1)));

  p_off_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == 3'd0) |=> (pend_count <= $past(pend_count)));

  p_rsv_rate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code[2] && rate_code[1]) |=> (pend_count <= $past(pend_count)));

  p_rsv_freq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    freq_sel[0] |=> (pend_count <= $past(pend_count)));

  p_enable_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh_en |=> (pend_count <= $past(pend_count)));

  p_idle_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_ack && !refresh_req && !expire) |=> (pend_count == '0));

  p_collide_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && refresh_ack && refresh_req) |=> $stable(pend_count));

endmodule

bind refresh_timer refresh_timer_chk #(
  .PEND_MAX (PEND_MAX),
  .PEND_W   (PEND_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rate_code   (rate_code),
  .freq_sel    (freq_sel),
  .refresh_en  (refresh_en),
  .refresh_ack (refresh_ack),
  .refresh_req (refresh_req),
  .pend_count  (pend_count),
  .expire      (expire)
);

// File: tb/refresh_timer_test.sv
`timescale 1ns/1ps
module refresh_timer_test;

  localparam int BF = 20;
  localparam int BS = 13;
  localparam int PM = 8;
  localparam int PW = $clog2(PM + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    rate_code = 3'd0;
  logic [1:0]    freq_sel = 2'b00;
  logic          refresh_en = 1'b0;
  logic          refresh_ack = 1'b0;
  logic          refresh_req;
  logic [PW-1:0] pend_count;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  refresh_timer #(.BASE_FAST(BF), .BASE_SLOW(BS), .PEND_MAX(PM)) uut (
    .clk(clk), .rst_n(rst_n), .rate_code(rate_code), .freq_sel(freq_sel),
    .refresh_en(refresh_en), .refresh_ack(refresh_ack),
    .refresh_req(refresh_req), .pend_count(pend_count)
  );

  // {freq[1:0], rate[2:0], cycles from start edge to first visible request (interval+1)}
  localparam logic [15:0] VEC [10] = '{
    {2'b00, 3'd1, 11'd21},  {2'b00, 3'd2, 11'd41},  {2'b00, 3'd3, 11'd81},
    {2'b00, 3'd4, 11'd161}, {2'b00, 3'd5, 11'd321},
    {2'b10, 3'd1, 11'd14},  {2'b10, 3'd2, 11'd27},  {2'b10, 3'd3, 11'd53},
    {2'b10, 3'd4, 11'd105}, {2'b10, 3'd5, 11'd209}
  };

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drain();
    refresh_en = 1'b0;
    @(negedge clk);
    while (refresh_req) begin
      refresh_ack = 1'b1;
      @(negedge clk);
      refresh_ack = 1'b0;
    end
  endtask

  task automatic measure(output int k);
    k = 0;
    do begin
      @(posedge clk);
      k++;
      @(negedge clk);
    end while (!refresh_req && k < 1000);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    int k;
    // R1: reset state, even with the timer configured to run
    rate_code = 3'd1; freq_sel = 2'b00; refresh_en = 1'b1;
    cycles(30);
    check("R1 req in reset", int'(refresh_req), 0);
    check("R1 count in reset", int'(pend_count), 0);
    refresh_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 req after reset", int'(refresh_req), 0);
    check("R1 count after reset", int'(pend_count), 0);

    // R2 / R3: interval table
    foreach (VEC[i]) begin
      drain();
      freq_sel  = VEC[i][15:14];
      rate_code = VEC[i][13:11];
      refresh_en = 1'b1;
      measure(k);
      check(VEC[i][15:14] == 2'b00 ? "R2 interval 100MHz" : "R3 interval 66MHz",
            k, int'(VEC[i][10:0]));
      check("R2 single pending", int'(pend_count), 1);
    end

    // R4: off code
    drain();
    rate_code = 3'd0; freq_sel = 2'b00; refresh_en = 1'b1;
    cycles(400);
    check("R4 off code count", int'(pend_count), 0);

    // R5: reserved rate codes
    drain();
    rate_code = 3'd6; refresh_en = 1'b1;
    cycles(400);
    check("R5 rate 110", int'(pend_count), 0);
    rate_code = 3'd7;
    cycles(400);
    check("R5 rate 111", int'(pend_count), 0);

    // R6: reserved frequency codes
    rate_code = 3'd1; freq_sel = 2'b01;
    cycles(100);
    check("R6 freq 01", int'(pend_count), 0);
    freq_sel = 2'b11;
    cycles(100);
    check("R6 freq 11", int'(pend_count), 0);

    // R7 / R8: build three pending, then disable and hold
    drain();
    rate_code = 3'd1; freq_sel = 2'b00; refresh_en = 1'b1;
    cycles(70);
    refresh_en = 1'b0;
    check("R9 accumulate to three", int'(pend_count), 3);
    cycles(400);
    check("R7 count kept while disabled", int'(pend_count), 3);
    check("R8 req held without ack", int'(refresh_req), 1);
    for (int n = 2; n >= 0; n--) begin
      refresh_ack = 1'b1;
      @(negedge clk);
      refresh_ack = 1'b0;
      check("R8 ack step", int'(pend_count), n);
      check("R8 req tracks count", int'(refresh_req), n != 0 ? 1 : 0);
    end

    // R11: ack with nothing pending
    refresh_ack = 1'b1;
    cycles(3);
    refresh_ack = 1'b0;
    @(negedge clk);
    check("R11 idle ack", int'(pend_count), 0);

    // R9: saturation
    rate_code = 3'd1; freq_sel = 2'b00; refresh_en = 1'b1;
    cycles(20 * 12);
    check("R9 saturate", int'(pend_count), PM);
    check("R9 req high", int'(refresh_req), 1);

    // R12: expiry and ack in the same cycle
    drain();
    refresh_en = 1'b1;
    cycles(40);
    check("R12 one pending before collision", int'(pend_count), 1);
    refresh_ack = 1'b1;
    @(negedge clk);
    refresh_ack = 1'b0;
    check("R12 collision unchanged", int'(pend_count), 1);

    // R10: rate change restarts
    drain();
    rate_code = 3'd1; freq_sel = 2'b00; refresh_en = 1'b1;
    cycles(10);
    rate_code = 3'd2;
    measure(k);
    check("R10 rate change restart", k, 41);
    drain();
    rate_code = 3'd1; freq_sel = 2'b00; refresh_en = 1'b1;
    cycles(15);
    freq_sel = 2'b10;
    measure(k);
    check("R10 freq change restart", k, 14);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule